// File: doc/BRIEF.md
# Paged Program Counter Unit

This block produces the instruction fetch address for a small 8-bit core whose program counter is 13 bits wide and whose program memory is split into pages. In each instruction cycle the core presents one control command. The command may be a sequential step, an absolute jump or a subroutine call with an 11-bit immediate, a computed jump that writes the low byte of the counter, a return, a return that also carries an 8-bit literal for the accumulator, or a taken skip. An interrupt request can also send the counter to a fixed vector. A software-written page latch supplies the address bits that the instruction cannot carry. Immediate transfers take only the two top latch bits, which gives 2K-word pages. Computed jumps take all five latch bits, which gives 256-word pages. The latch never changes by itself, including when sequential fetch runs across a page boundary.

Each taken transfer costs one dead cycle. For one instruction cycle the unit raises a flush flag, and the core must discard the word that was fetched before the transfer. While that flag is high the unit ignores the command, the interrupt request and any latch write, and simply steps the counter by one. Return addresses go to an 8-entry hardware stack that software cannot read or write. The stack wraps silently when it overflows or underflows.

Top module: `pgpc_unit`

## Requirements
- R1: After reset, fetch_addr_o is 0, flush_o is 0, acc_we_o is 0, the page latch is 0 and the return stack is empty with every entry 0.
- R2: A cycle with adv_i high, flush_o low, irq_i low and cmd_i = 0 (step) advances fetch_addr_o by one modulo 8192 and leaves flush_o low. A cycle with adv_i low changes nothing.
- R3: cmd_i = 1 (jump) loads fetch_addr_o with {latch[4:3], imm_i[10:0]} and raises flush_o for the next instruction cycle.
- R4: cmd_i = 2 (call) loads the same target as R3, raises flush_o, and pushes the fetch address held in that cycle onto the return stack.
- R5: cmd_i = 5 (computed jump) loads fetch_addr_o with {latch[4:0], data_i[7:0]} and raises flush_o.
- R6: cmd_i = 3 (return) pops the return stack into fetch_addr_o and raises flush_o. cmd_i = 4 (return with literal) does the same and also pulses acc_we_o for one cycle with acc_lit_o equal to data_i.
- R7: cmd_i = 6 (taken skip) advances fetch_addr_o by one and raises flush_o.
- R8: In an instruction cycle where flush_o is high, cmd_i, irq_i and latch_we_i are ignored: the address advances by one and flush_o falls.
- R9: irq_i, when not ignored by R8, overrides cmd_i. It pushes the current fetch address, loads the vector 0x004 and raises flush_o.
- R10: The stack holds 8 entries and is circular. A ninth push overwrites the oldest entry, and a pop from an empty stack returns the entry at the wrapped position. No error is flagged.
- R11: latch_we_i with adv_i high writes data_i[4:0] into the page latch. The new value only affects transfers in later cycles. Sequential steps across a page boundary never alter the latch.
- R12: The unused code cmd_i = 7 behaves as a sequential step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Instruction cycle enable |
| cmd_i | input | 3 | Control command code for the executing instruction |
| imm_i | input | 11 | Immediate target of jump and call |
| data_i | input | 8 | Low-byte value for computed jump, literal for return, latch write data |
| latch_we_i | input | 1 | Write data_i[4:0] into the page latch |
| irq_i | input | 1 | Interrupt vectoring request |
| fetch_addr_o | output | 13 | Current program fetch address |
| flush_o | output | 1 | Discard the instruction word now in decode |
| acc_we_o | output | 1 | Accumulator load pulse from return with literal |
| acc_lit_o | output | 8 | Literal for the accumulator |

## Verification
The bound properties check, in every cycle, the local effect of each single command. They cover the one-step advance, holding while adv_i is low, the low immediate bits of jump and call targets, the low byte of computed jumps, the skip, the interrupt vector, the literal pulse and the forced sequential step in a dead cycle. Some behaviours depend on history and only the bench scenarios can show them. These are the page bits drawn from an earlier latch write, a latch write that is dropped during a flush cycle, return addresses coming back in LIFO order, and the circular overwrite and wrap after nine calls and nine returns.

// File: rtl/pgpc_pkg.sv
`timescale 1ns/1ps
package pgpc_pkg;

   // command codes presented by the core each instruction cycle
   typedef enum logic [2:0] {
      PC_SEQ    = 3'd0,
      PC_GOTO   = 3'd1,
      PC_CALL   = 3'd2,
      PC_RET    = 3'd3,
      PC_RETLIT = 3'd4,
      PC_PCLWR  = 3'd5,
      PC_SKIP   = 3'd6
   } pc_cmd_e;

   // one-hot-ish action set decided for a cycle
   typedef struct packed {
      logic load;     // instruction cycle happens
      logic seq;      // next = current + 1
      logic imm;      // next = immediate-page target
      logic pcl;      // next = low-byte-page target
      logic pop;      // next = stack top
      logic vec;      // next = interrupt vector
      logic push;     // save current address
      logic flush;    // kill the prefetched word
      logic acc_we;   // literal goes to accumulator
      logic wr_ok;    // side effects (latch write) allowed
   } pc_act_t;

endpackage

// File: rtl/pgpc_decide.sv
`timescale 1ns/1ps
module pgpc_decide
   import pgpc_pkg::*;
(
   input  logic       adv_i,
   input  logic       kill_i,
   input  logic       irq_i,
   input  logic [2:0] cmd_i,
   output pc_act_t    act_o
);

   always_comb begin
      act_o = '0;
      if (adv_i) begin
         act_o.load = 1'b1;
         if (kill_i) begin
            // dead cycle: the word in decode is discarded
            act_o.seq = 1'b1;
         end else begin
            act_o.wr_ok = 1'b1;
            if (irq_i) begin
               act_o.vec   = 1'b1;
               act_o.push  = 1'b1;
               act_o.flush = 1'b1;
            end else begin
               case (cmd_i)
                  PC_GOTO: begin
                     act_o.imm   = 1'b1;
                     act_o.flush = 1'b1;
                  end
                  PC_CALL: begin
                     act_o.imm   = 1'b1;
                     act_o.push  = 1'b1;
                     act_o.flush = 1'b1;
                  end
                  PC_RET: begin
                     act_o.pop   = 1'b1;
                     act_o.flush = 1'b1;
                  end
                  PC_RETLIT: begin
                     act_o.pop    = 1'b1;
                     act_o.flush  = 1'b1;
                     act_o.acc_we = 1'b1;
                  end
                  PC_PCLWR: begin
                     act_o.pcl   = 1'b1;
                     act_o.flush = 1'b1;
                  end
                  PC_SKIP: begin
                     act_o.seq   = 1'b1;
                     act_o.flush = 1'b1;
                  end
                  default: act_o.seq = 1'b1;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/pgpc_target.sv
`timescale 1ns/1ps
module pgpc_target #(
   parameter int unsigned PC_W  = 13,
   parameter int unsigned IMM_W = 11,
   parameter int unsigned PCL_W = 8,
   localparam int unsigned LATCH_W = PC_W - PCL_W
) (
   input  logic [LATCH_W-1:0] latch_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [PCL_W-1:0]   pcl_i,
   output logic [PC_W-1:0]    imm_tgt_o,
   output logic [PC_W-1:0]    pcl_tgt_o
);

   localparam int unsigned IMM_UP = (PC_W > IMM_W) ? PC_W - IMM_W : 0;

   generate
      if (IMM_UP > LATCH_W) begin : g_bad_imm
         $error("pgpc_target: immediate page needs more latch bits than exist");
      end

      if (IMM_UP == 0) begin : g_imm_full
         // immediate covers the whole counter: no paging for jumps
         assign imm_tgt_o = imm_i[PC_W-1:0];
      end else begin : g_imm_paged
         assign imm_tgt_o = {latch_i[LATCH_W-1 -: IMM_UP], imm_i};
      end
   endgenerate

   // computed jump: every upper bit comes from the latch
   assign pcl_tgt_o = {latch_i, pcl_i};

endmodule

// File: rtl/pgpc_retstack.sv
`timescale 1ns/1ps
module pgpc_retstack #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] push_d_i,
   output logic [AW-1:0] top_o
);

   localparam int unsigned SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pgpc_retstack: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [SP_W-1:0]     sp_q;
   logic [SP_W-1:0]     sp_dec;
   logic [DEPTH*AW-1:0] flat;

   assign sp_dec = sp_q - 1'b1;

   // pointer wraps with the natural modulo of its width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sp_q <= '0;
      else if (push_i) sp_q <= sp_q + 1'b1;
      else if (pop_i)  sp_q <= sp_dec;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic [AW-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               val_q <= '0;
            else if (push_i && sp_q == SP_W'(i))
               val_q <= push_d_i;
         end
         assign flat[i*AW +: AW] = val_q;
      end
   endgenerate

   assign top_o = flat[int'(sp_dec)*AW +: AW];

endmodule

// File: rtl/pgpc_unit.sv
`timescale 1ns/1ps
module pgpc_unit
   import pgpc_pkg::*;
#(
   parameter int unsigned PC_W    = 13,
   parameter int unsigned IMM_W   = 11,
   parameter int unsigned PCL_W   = 8,
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned IRQ_VEC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [2:0]       cmd_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [PCL_W-1:0] data_i,
   input  logic             latch_we_i,
   input  logic             irq_i,
   output logic [PC_W-1:0]  fetch_addr_o,
   output logic             flush_o,
   output logic             acc_we_o,
   output logic [PCL_W-1:0] acc_lit_o
);

   localparam int unsigned LATCH_W = PC_W - PCL_W;

   generate
      if (PC_W <= PCL_W || LATCH_W > PCL_W) begin : g_bad_width
         $error("pgpc_unit: latch width must be between 1 and PCL_W");
      end
      if (IMM_W > PC_W) begin : g_bad_imm
         $error("pgpc_unit: immediate wider than program counter");
      end
   endgenerate

   logic [PC_W-1:0]    pc_q;
   logic [PC_W-1:0]    pc_n;
   logic [PC_W-1:0]    imm_tgt;
   logic [PC_W-1:0]    pcl_tgt;
   logic [PC_W-1:0]    stk_top;
   logic [LATCH_W-1:0] latch_q;
   logic               flush_q;
   logic               acc_we_q;
   logic [PCL_W-1:0]   acc_lit_q;
   pc_act_t            act;

   pgpc_decide u_decide (
      .adv_i  (adv_i),
      .kill_i (flush_q),
      .irq_i  (irq_i),
      .cmd_i  (cmd_i),
      .act_o  (act)
   );

   pgpc_target #(
      .PC_W  (PC_W),
      .IMM_W (IMM_W),
      .PCL_W (PCL_W)
   ) u_target (
      .latch_i   (latch_q),
      .imm_i     (imm_i),
      .pcl_i     (data_i),
      .imm_tgt_o (imm_tgt),
      .pcl_tgt_o (pcl_tgt)
   );

   pgpc_retstack #(
      .DEPTH (DEPTH),
      .AW    (PC_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (act.push),
      .pop_i    (act.pop),
      .push_d_i (pc_q),
      .top_o    (stk_top)
   );

   always_comb begin
      pc_n = pc_q;
      if (act.vec)      pc_n = PC_W'(IRQ_VEC);
      else if (act.imm) pc_n = imm_tgt;
      else if (act.pcl) pc_n = pcl_tgt;
      else if (act.pop) pc_n = stk_top;
      else if (act.seq) pc_n = pc_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         flush_q <= 1'b0;
      end else if (act.load) begin
         pc_q    <= pc_n;
         flush_q <= act.flush;
      end
   end

   // latch only changes on an explicit software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latch_q <= '0;
      else if (act.wr_ok && latch_we_i)
         latch_q <= data_i[LATCH_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_we_q  <= 1'b0;
         acc_lit_q <= '0;
      end else begin
         acc_we_q <= act.acc_we;
         if (act.acc_we) acc_lit_q <= data_i;
      end
   end

   assign fetch_addr_o = pc_q;
   assign flush_o      = flush_q;
   assign acc_we_o     = acc_we_q;
   assign acc_lit_o    = acc_lit_q;

endmodule

// File: rtl/pgpc_checker.sv
`timescale 1ns/1ps
module pgpc_checker
   import pgpc_pkg::*;
#(
   parameter int unsigned PC_W    = 13,
   parameter int unsigned IMM_W   = 11,
   parameter int unsigned PCL_W   = 8,
   parameter int unsigned IRQ_VEC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv_i,
   input logic [2:0]       cmd_i,
   input logic [IMM_W-1:0] imm_i,
   input logic [PCL_W-1:0] data_i,
   input logic             irq_i,
   input logic [PC_W-1:0]  fetch_addr_o,
   input logic             flush_o,
   input logic             acc_we_o,
   input logic [PCL_W-1:0] acc_lit_o
);

   logic live;
   assign live = adv_i && !flush_o && !irq_i;

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_SEQ |=> !flush_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(fetch_addr_o) && $stable(flush_o) && !acc_we_o);

   assert_goto_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_GOTO |=> flush_o && fetch_addr_o[IMM_W-1:0] == $past(imm_i));

   assert_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_CALL |=> flush_o && fetch_addr_o[IMM_W-1:0] == $past(imm_i));

   assert_pclwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_PCLWR |=> flush_o && fetch_addr_o[PCL_W-1:0] == $past(data_i));

   assert_retlit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_RETLIT |=> flush_o && acc_we_o && acc_lit_o == $past(data_i));

   assert_acc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we_o |=> !acc_we_o);

   assert_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == PC_SKIP |=> flush_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

   assert_flush_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && flush_o |=> !flush_o && !acc_we_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

   assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !flush_o && irq_i |=> flush_o && fetch_addr_o == PC_W'(IRQ_VEC));

   assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
      live && cmd_i == 3'd7 |=> !flush_o && fetch_addr_o == PC_W'($past(fetch_addr_o) + 1'b1));

endmodule

bind pgpc_unit pgpc_checker #(
   .PC_W    (PC_W),
   .IMM_W   (IMM_W),
   .PCL_W   (PCL_W),
   .IRQ_VEC (IRQ_VEC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adv_i        (adv_i),
   .cmd_i        (cmd_i),
   .imm_i        (imm_i),
   .data_i       (data_i),
   .irq_i        (irq_i),
   .fetch_addr_o (fetch_addr_o),
   .flush_o      (flush_o),
   .acc_we_o     (acc_we_o),
   .acc_lit_o    (acc_lit_o)
);

// File: tb/sim_pgpc_unit.sv
`timescale 1ns/1ps
module sim_pgpc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 1'b0;
   logic [2:0]  cmd_i = 3'd0;
   logic [10:0] imm_i = '0;
   logic [7:0]  data_i = '0;
   logic        latch_we_i = 1'b0;
   logic        irq_i = 1'b0;
   logic [12:0] fetch_addr_o;
   logic        flush_o;
   logic        acc_we_o;
   logic [7:0]  acc_lit_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pgpc_unit u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv_i        (adv_i),
      .cmd_i        (cmd_i),
      .imm_i        (imm_i),
      .data_i       (data_i),
      .latch_we_i   (latch_we_i),
      .irq_i        (irq_i),
      .fetch_addr_o (fetch_addr_o),
      .flush_o      (flush_o),
      .acc_we_o     (acc_we_o),
      .acc_lit_o    (acc_lit_o)
   );

   typedef struct packed {
      logic [12:0] pc;
      logic        fl;
      logic        we;
      logic [7:0]  lit;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   // reference state, derived from the requirements
   logic [12:0] m_pc = '0;
   logic        m_fl = 1'b0;
   logic [4:0]  m_latch = '0;
   logic [12:0] m_stk [8];
   int          m_sp = 0;

   task automatic m_push(input logic [12:0] v);
      m_stk[m_sp] = v;
      m_sp = (m_sp + 1) % 8;
   endtask

   task automatic m_pop();
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
   endtask

   // driver: apply one cycle of stimulus and queue the expected outcome
   task automatic step(input logic adv, input logic [2:0] cmd, input logic [10:0] imm,
                       input logic [7:0] dat, input logic lwe, input logic irq, input string tag);
      exp_t e;
      @(negedge clk);
      adv_i = adv; cmd_i = cmd; imm_i = imm; data_i = dat; latch_we_i = lwe; irq_i = irq;
      e.we  = 1'b0;
      e.lit = 8'h00;
      if (adv) begin
         if (m_fl) begin
            m_pc = m_pc + 13'd1;
            m_fl = 1'b0;
         end else begin
            if (irq) begin
               m_push(m_pc); m_pc = 13'h004; m_fl = 1'b1;
            end else begin
               case (cmd)
                  3'd1: begin m_pc = {m_latch[4:3], imm}; m_fl = 1'b1; end
                  3'd2: begin m_push(m_pc); m_pc = {m_latch[4:3], imm}; m_fl = 1'b1; end
                  3'd3: begin m_pop(); m_fl = 1'b1; end
                  3'd4: begin m_pop(); m_fl = 1'b1; e.we = 1'b1; e.lit = dat; end
                  3'd5: begin m_pc = {m_latch, dat}; m_fl = 1'b1; end
                  3'd6: begin m_pc = m_pc + 13'd1; m_fl = 1'b1; end
                  default: begin m_pc = m_pc + 13'd1; m_fl = 1'b0; end
               endcase
            end
            if (lwe) m_latch = dat[4:0];
         end
      end
      e.pc = m_pc;
      e.fl = m_fl;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (fetch_addr_o !== e.pc || flush_o !== e.fl || acc_we_o !== e.we ||
                (e.we && acc_lit_o !== e.lit)) begin
               n_bad++;
               $display("FAIL %s: actual pc=%h fl=%b we=%b lit=%h expected pc=%h fl=%b we=%b lit=%h",
                        t, fetch_addr_o, flush_o, acc_we_o, acc_lit_o, e.pc, e.fl, e.we, e.lit);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      // R1 reset state
      n_chk++;
      if (fetch_addr_o !== 13'h0 || flush_o !== 1'b0 || acc_we_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: actual pc=%h fl=%b we=%b expected pc=0000 fl=0 we=0",
                  fetch_addr_o, flush_o, acc_we_o);
      end

      // R2 sequential and hold
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 step");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 step");
      step(0, 3'd1, 11'h7FF, 8'hFF, 1, 1, "R2 hold");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 step");
      // R11 latch write, then jump uses it (R3)
      step(1, 3'd0, 11'h0, 8'h16, 1, 0, "R11 latch write");
      step(1, 3'd1, 11'h123, 8'h00, 0, 0, "R3 jump page");
      // R8 dead cycle ignores command, irq and latch write
      step(1, 3'd1, 11'h555, 8'h1F, 1, 1, "R8 dead cycle");
      step(1, 3'd1, 11'h00A, 8'h00, 0, 0, "R8 latch kept R3");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      // R4 call, R6 return with literal
      step(1, 3'd2, 11'h055, 8'h00, 0, 0, "R4 call");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 step");
      step(1, 3'd4, 11'h0, 8'hA5, 0, 0, "R6 return literal");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R6 pulse ends");
      // R5 computed jump
      step(1, 3'd5, 11'h0, 8'h3C, 0, 0, "R5 computed jump");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      // R7 skip
      step(1, 3'd6, 11'h0, 8'h00, 0, 0, "R7 skip");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R7 dead");
      // R9 interrupt overrides jump, then R6 plain return
      step(1, 3'd1, 11'h3FF, 8'h00, 0, 1, "R9 irq vector");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      step(1, 3'd3, 11'h0, 8'h00, 0, 0, "R6 return");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      // R12 reserved code
      step(1, 3'd7, 11'h7FF, 8'hFF, 0, 0, "R12 reserved");
      // R2 wrap at the top of memory, R11 latch unchanged by crossing
      step(1, 3'd0, 11'h0, 8'h1F, 1, 0, "R11 latch all ones");
      step(1, 3'd5, 11'h0, 8'hFF, 0, 0, "R5 to top");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 wrap via dead");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R2 step after wrap");
      step(1, 3'd1, 11'h000, 8'h00, 0, 0, "R11 latch survives crossing");
      step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R8 dead");
      // R10 nine calls then nine returns
      for (int k = 0; k < 9; k++) begin
         step(1, 3'd2, 11'(16 * (k + 1)), 8'h00, 0, 0, "R10 call");
         step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R10 dead");
      end
      for (int k = 0; k < 9; k++) begin
         step(1, 3'd3, 11'h0, 8'h00, 0, 0, "R10 return");
         step(1, 3'd0, 11'h0, 8'h00, 0, 0, "R10 dead");
      end
      step(0, 3'd0, 11'h0, 8'h00, 0, 0, "R2 hold end");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule